// File: doc/BRIEF.md
# Config-Space Mailbox Discovery Responder

This block is the endpoint side of a data-object mailbox in a PCIe function's extended configuration space. Software reaches it through 32-bit configuration reads and writes at four fixed offsets above a capability base: control, status, write-data and read-data. It writes a request one dword at a time into the write-data register. It then starts processing by setting the GO bit in control, polls status, and collects the reply from the read-data register.

The only request the block answers is discovery, with object type 0 under the standards-body vendor ID 0x0001. It answers with a single protocol entry that advertises protocol 1 (component authentication) and says that no further entries follow. Any other request puts the mailbox into an error state. An ABORT in control returns the mailbox to idle from any state.

Reading read-data does not consume a dword. Software writes any value to read-data to step to the next reply dword. Configuration reads return data one cycle after the strobe, marked by a valid pulse. The reset input is asserted asynchronously and released on the clock.

Top module: `doe_mailbox`

## Requirements
- R1: With base B (default 0x100), control is at B+0x08, status at B+0x0C, write-data at B+0x10 and read-data at B+0x14. A read strobe returns `cfg_rdata` with `cfg_rvalid` high in the next cycle. Exactly one valid pulse follows each read strobe. A read at any other offset returns 0.
- R2: Each write to write-data stores the dword at the next request index, starting at 0. Once REQ_DEPTH dwords are held, further writes are dropped and never overwrite stored dwords.
- R3: Writing control with bit 31 (GO) set decodes request dword 0, taking the vendor ID from bits [15:0] and the object type from bits [23:16]. If the vendor ID is not 0x0001 or the type is not 0, status shows the error bit and read-data returns 0.
- R4: A valid discovery request produces exactly three reply dwords, in this order: a copy of request dword 0; 0x00000003 (length 3 in bits [17:0]); and 0x00010001 (vendor 0x0001 in [15:0], protocol 1 in [23:16], next index 0 in [31:24]).
- R5: Status reads 0x80000000 (ready, bit 31) while reply dwords remain, 0x00000004 (error, bit 2) after a rejected request, and 0 otherwise.
- R6: Reading read-data returns the reply dword at the read pointer and changes nothing; repeated reads return the same value.
- R7: A write of any value to read-data advances the read pointer and reduces the remaining count, but only while dwords remain. With none left, the write has no effect and read-data returns 0.
- R8: Writing control with bit 0 (ABORT) set clears the request index, the read pointer and the remaining count, which also clears the error. If GO and ABORT are set in the same write, ABORT takes precedence.
- R9: Bits [7:0] of request dword 2 give the requested entry index. The reply is identical for every index, since only one entry exists.
- R10: GO also rewinds the request index, so the next request is stored from dword 0 without an abort in between.
- R11: After reset, status reads 0 and read-data reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_off | input | 12 | Byte offset of the access in configuration space |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |

## Verification
Some behaviours are checked on every cycle by the bound checker:
- the read latency;
- the cap on the request index;
- the legal range of the remaining count;
- that reads leave the mailbox state untouched;
- that an acknowledge steps the pointer only while dwords remain;
- that abort clears all pointers.

Other behaviours can only be shown by the bench's scenarios, because they depend on the values carried through the reply:
- the exact reply dwords and the status encodings;
- the copy of a fresh header after GO without an abort, which shows the request index was rewound;
- the independence of the reply from the entry index;
- that a write beyond capacity leaves dword 0 intact.

// File: rtl/doe_mbx_pkg.sv
package doe_mbx_pkg;
  // register offsets from the capability base
  localparam logic [11:0] OFF_CTRL = 12'h008;
  localparam logic [11:0] OFF_STAT = 12'h00C;
  localparam logic [11:0] OFF_WMBX = 12'h010;
  localparam logic [11:0] OFF_RMBX = 12'h014;

  // control and status bit positions
  localparam int CTL_ABORT_BIT = 0;
  localparam int CTL_GO_BIT    = 31;
  localparam int STS_ERR_BIT   = 2;
  localparam int STS_RDY_BIT   = 31;

  // object header values
  localparam logic [15:0] SIG_VID   = 16'h0001;
  localparam logic [7:0]  TYPE_DISC = 8'h00;
  localparam logic [7:0]  PROT_AUTH = 8'h01;

  localparam int RSP_LEN   = 3;
  localparam int NUM_PROTS = 1;

  typedef struct packed {
    logic [7:0]  rsvd;
    logic [7:0]  obj_type;
    logic [15:0] vid;
  } obj_hdr_t;
endpackage

// File: rtl/doe_addr_dec.sv
module doe_addr_dec
  import doe_mbx_pkg::*;
#(
  parameter logic [11:0] CAP_BASE = 12'h100
) (
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [11:0] cfg_off,
  output logic        ctrl_wr,
  output logic        wmbx_wr,
  output logic        rmbx_wr,
  output logic        stat_rd,
  output logic        rmbx_rd
);
  localparam logic [11:0] A_CTRL = CAP_BASE + OFF_CTRL;
  localparam logic [11:0] A_STAT = CAP_BASE + OFF_STAT;
  localparam logic [11:0] A_WMBX = CAP_BASE + OFF_WMBX;
  localparam logic [11:0] A_RMBX = CAP_BASE + OFF_RMBX;

  always_comb begin
    ctrl_wr = cfg_wr && (cfg_off == A_CTRL);
    wmbx_wr = cfg_wr && (cfg_off == A_WMBX);
    rmbx_wr = cfg_wr && (cfg_off == A_RMBX);
    stat_rd = cfg_rd && (cfg_off == A_STAT);
    rmbx_rd = cfg_rd && (cfg_off == A_RMBX);
  end
endmodule

// File: rtl/doe_req_store.sv
module doe_req_store #(
  parameter  int DEPTH = 1024,
  localparam int IW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [31:0]   push_dw,
  input  logic          rewind,
  output logic [31:0]   hdr_dw,
  output logic [7:0]    req_index,
  output logic [IW-1:0] wr_idx
);
  localparam int AW = IW - 1;

  logic [31:0]   mem [DEPTH];
  logic [IW-1:0] idx_q, idx_d;
  logic          room;
  logic          take;

  assign room = (idx_q < IW'(DEPTH));
  assign take = push && room;

  always_comb begin
    idx_d = idx_q;
    if (take)   idx_d = idx_q + IW'(1);
    if (rewind) idx_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  always_ff @(posedge clk) begin
    if (take) mem[idx_q[AW-1:0]] <= push_dw;
  end

  assign hdr_dw    = mem[0];
  assign req_index = mem[2][7:0];
  assign wr_idx    = idx_q;
endmodule

// File: rtl/doe_rsp_engine.sv
module doe_rsp_engine
  import doe_mbx_pkg::*;
#(
  parameter  int RSP_DEPTH = 4,
  localparam int PW        = $clog2(RSP_DEPTH) + 1,
  localparam int CW        = $clog2(RSP_DEPTH + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic                 abort,
  input  logic                 ack,
  input  logic [31:0]          hdr_dw,
  input  logic [7:0]           req_index,
  output logic signed [CW-1:0] rem,
  output logic [PW-1:0]        rd_ptr,
  output logic [31:0]          cur_dw,
  output logic                 ready,
  output logic                 error
);
  localparam int AW = PW - 1;

  obj_hdr_t              hdr;
  logic                  hdr_ok;
  logic [7:0]            nxt_index;
  logic signed [CW-1:0]  rem_q, rem_d;
  logic [PW-1:0]         ptr_q, ptr_d;
  logic                  load;
  logic [31:0]           rsp_q [RSP_DEPTH];
  logic [31:0]           rsp_new [RSP_DEPTH];

  assign hdr    = obj_hdr_t'(hdr_dw);
  assign hdr_ok = (hdr.vid == SIG_VID) && (hdr.obj_type == TYPE_DISC);

  // only one entry: the following index always wraps to 0
  assign nxt_index = ((9'(req_index) + 9'd1) >= 9'(NUM_PROTS)) ? 8'd0
                                                                : req_index + 8'd1;

  always_comb begin
    rem_d = rem_q;
    ptr_d = ptr_q;
    load  = 1'b0;
    if (go) begin
      ptr_d = '0;
      if (hdr_ok) begin
        rem_d = CW'(RSP_LEN);
        load  = 1'b1;
      end else begin
        rem_d = '1;
      end
    end else if (ack && (rem_q > 0)) begin
      rem_d = rem_q - CW'(1);
      ptr_d = ptr_q + PW'(1);
    end
    if (abort) begin
      rem_d = '0;
      ptr_d = '0;
      load  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      ptr_q <= '0;
    end else begin
      rem_q <= rem_d;
      ptr_q <= ptr_d;
    end
  end

  for (genvar i = 0; i < RSP_DEPTH; i++) begin : g_rsp
    if (i == 0) begin : g_echo
      assign rsp_new[i] = hdr_dw;
    end else if (i == 1) begin : g_len
      assign rsp_new[i] = 32'(RSP_LEN);
    end else if (i == 2) begin : g_entry
      assign rsp_new[i] = {nxt_index, PROT_AUTH, SIG_VID};
    end else begin : g_pad
      assign rsp_new[i] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rsp_q[i] <= '0;
      else if (load) rsp_q[i] <= rsp_new[i];
    end
  end

  assign ready  = (rem_q > 0);
  assign error  = (rem_q < 0);
  assign cur_dw = ready ? rsp_q[ptr_q[AW-1:0]] : 32'd0;
  assign rem    = rem_q;
  assign rd_ptr = ptr_q;
endmodule

// File: rtl/doe_mailbox.sv
module doe_mailbox
  import doe_mbx_pkg::*;
#(
  parameter logic [11:0] CAP_BASE  = 12'h100,
  parameter int          REQ_DEPTH = 1024,
  parameter int          RSP_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [11:0] cfg_off,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_rvalid
);
  localparam int IW = $clog2(REQ_DEPTH) + 1;
  localparam int PW = $clog2(RSP_DEPTH) + 1;
  localparam int CW = $clog2(RSP_DEPTH + 1) + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic ctrl_wr, wmbx_wr, rmbx_wr, stat_rd, rmbx_rd;
  logic go_cmd, abort_cmd;

  doe_addr_dec #(.CAP_BASE(CAP_BASE)) u_dec (
    .cfg_wr  (cfg_wr),
    .cfg_rd  (cfg_rd),
    .cfg_off (cfg_off),
    .ctrl_wr (ctrl_wr),
    .wmbx_wr (wmbx_wr),
    .rmbx_wr (rmbx_wr),
    .stat_rd (stat_rd),
    .rmbx_rd (rmbx_rd)
  );

  assign go_cmd    = ctrl_wr && cfg_wdata[CTL_GO_BIT];
  assign abort_cmd = ctrl_wr && cfg_wdata[CTL_ABORT_BIT];

  logic [31:0]   hdr_dw;
  logic [7:0]    req_index;
  logic [IW-1:0] wr_idx;

  doe_req_store #(.DEPTH(REQ_DEPTH)) u_req (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .push      (wmbx_wr),
    .push_dw   (cfg_wdata),
    .rewind    (go_cmd || abort_cmd),
    .hdr_dw    (hdr_dw),
    .req_index (req_index),
    .wr_idx    (wr_idx)
  );

  logic signed [CW-1:0] rem;
  logic [PW-1:0]        rd_ptr;
  logic [31:0]          cur_dw;
  logic                 ready, error;

  doe_rsp_engine #(.RSP_DEPTH(RSP_DEPTH)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .go        (go_cmd),
    .abort     (abort_cmd),
    .ack       (rmbx_wr),
    .hdr_dw    (hdr_dw),
    .req_index (req_index),
    .rem       (rem),
    .rd_ptr    (rd_ptr),
    .cur_dw    (cur_dw),
    .ready     (ready),
    .error     (error)
  );

  // read return path, one register stage
  logic [31:0] sts_word;
  logic [31:0] rdata_d, rdata_q;
  logic        rvalid_q;

  always_comb begin
    sts_word              = '0;
    sts_word[STS_RDY_BIT] = ready;
    sts_word[STS_ERR_BIT] = error;
    rdata_d = '0;
    if (stat_rd) rdata_d = sts_word;
    if (rmbx_rd) rdata_d = cur_dw;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cfg_rd;
      if (cfg_rd) rdata_q <= rdata_d;
    end
  end

  assign cfg_rdata  = rdata_q;
  assign cfg_rvalid = rvalid_q;
endmodule

// File: rtl/doe_mailbox_chk.sv
module doe_mailbox_chk #(
  parameter int REQ_DEPTH = 1024,
  parameter int IW        = 11,
  parameter int PW        = 3,
  parameter int CW        = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_rd,
  input logic                 cfg_wr,
  input logic                 cfg_rvalid,
  input logic                 go_cmd,
  input logic                 abort_cmd,
  input logic                 ack,
  input logic [IW-1:0]        wr_idx,
  input logic signed [CW-1:0] rem,
  input logic [PW-1:0]        rd_ptr
);
  p_rvalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> cfg_rvalid);

  p_no_stray_rvalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> !cfg_rvalid);

  p_wr_idx_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx <= IW'(REQ_DEPTH));

  p_go_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_cmd && !abort_cmd) |=> ((rem == CW'(3)) || (rem == '1)) && (rd_ptr == '0) && (wr_idx == '0));

  p_rem_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rem >= -1) && (rem <= 3));

  p_read_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !cfg_wr) |=> $stable(rem) && $stable(rd_ptr));

  p_ack_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (rem > 0)) |=> (rem == $past(rem) - CW'(1)) && (rd_ptr == $past(rd_ptr) + PW'(1)));

  p_ack_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (rem <= 0)) |=> $stable(rem) && $stable(rd_ptr));

  p_abort_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_cmd |=> (rem == '0) && (rd_ptr == '0) && (wr_idx == '0));
endmodule

bind doe_mailbox doe_mailbox_chk #(
  .REQ_DEPTH (REQ_DEPTH),
  .IW        (IW),
  .PW        (PW),
  .CW        (CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_i_n),
  .cfg_rd     (cfg_rd),
  .cfg_wr     (cfg_wr),
  .cfg_rvalid (cfg_rvalid),
  .go_cmd     (go_cmd),
  .abort_cmd  (abort_cmd),
  .ack        (rmbx_wr),
  .wr_idx     (wr_idx),
  .rem        (rem),
  .rd_ptr     (rd_ptr)
);

// File: tb/tb_doe_mailbox.sv
module tb_doe_mailbox;
  localparam logic [11:0] BASE   = 12'h100;
  localparam logic [11:0] A_CTRL = BASE + 12'h008;
  localparam logic [11:0] A_STAT = BASE + 12'h00C;
  localparam logic [11:0] A_WMBX = BASE + 12'h010;
  localparam logic [11:0] A_RMBX = BASE + 12'h014;
  localparam int          DEPTH  = 1024;

  localparam logic [31:0] ST_RDY = 32'h8000_0000;
  localparam logic [31:0] ST_ERR = 32'h0000_0004;
  localparam logic [31:0] GO     = 32'h8000_0000;
  localparam logic [31:0] ABORT  = 32'h0000_0001;
  localparam logic [31:0] ENTRY  = 32'h0001_0001;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr, cfg_rd;
  logic [11:0] cfg_off;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  doe_mailbox #(.CAP_BASE(BASE), .REQ_DEPTH(DEPTH)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_rd     (cfg_rd),
    .cfg_off    (cfg_off),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .cfg_rvalid (cfg_rvalid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // monitor: compare every returned read against the scoreboard
  always @(negedge clk) begin
    if (cfg_rvalid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R1: unexpected read data actual=%h expected=<none>", cfg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (cfg_rdata !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, cfg_rdata, e);
        end
      end
    end
  end

  task automatic cfg_write(input logic [11:0] off, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_off = off; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [11:0] off, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    cfg_rd = 1'b1; cfg_off = off;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    cfg_rd = 1'b0;
  endtask

  task automatic send_req(input logic [31:0] h, input logic [31:0] idx);
    cfg_write(A_WMBX, h);
    cfg_write(A_WMBX, 32'h0000_0003);
    cfg_write(A_WMBX, idx);
    cfg_write(A_CTRL, GO);
  endtask

  task automatic finish_run();
    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_off = '0; cfg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R11 reset state, R1 unmapped offset
    cfg_read(A_STAT, 32'h0, "R11 status after reset");
    cfg_read(A_RMBX, 32'h0, "R11 read-data after reset");
    cfg_read(BASE,   32'h0, "R1 unmapped offset");

    // R4 R5 R6 R7 full exchange
    send_req(32'h0000_0001, 32'h0);
    cfg_read(A_STAT, ST_RDY, "R5 ready after GO");
    cfg_read(A_RMBX, 32'h0000_0001, "R4 dword0 echo");
    cfg_read(A_RMBX, 32'h0000_0001, "R6 repeated read");
    cfg_write(A_RMBX, 32'hDEAD_BEEF);
    cfg_read(A_RMBX, 32'h0000_0003, "R4 dword1 length");
    cfg_write(A_RMBX, 32'h0);
    cfg_read(A_STAT, ST_RDY, "R5 ready with one left");
    cfg_read(A_RMBX, ENTRY, "R4 dword2 entry");
    cfg_write(A_RMBX, 32'h1);
    cfg_read(A_STAT, 32'h0, "R5 idle after drain");
    cfg_read(A_RMBX, 32'h0, "R7 empty read");
    cfg_write(A_RMBX, 32'h1);
    cfg_read(A_STAT, 32'h0, "R7 ack when empty");

    // R10 and R9: new request without abort, nonzero index
    send_req(32'hAB00_0001, 32'h0000_0005);
    cfg_read(A_RMBX, 32'hAB00_0001, "R10 fresh header echoed");
    cfg_write(A_RMBX, 32'h0);
    cfg_write(A_RMBX, 32'h0);
    cfg_read(A_RMBX, ENTRY, "R9 entry independent of index");

    // R3 bad vendor
    send_req(32'h0000_0002, 32'h0);
    cfg_read(A_STAT, ST_ERR, "R3 error on vendor");
    cfg_read(A_RMBX, 32'h0, "R3 read-data zero on error");
    cfg_write(A_RMBX, 32'h0);
    cfg_read(A_STAT, ST_ERR, "R7 ack keeps error");
    cfg_write(A_CTRL, ABORT);
    cfg_read(A_STAT, 32'h0, "R8 abort clears error");

    // R3 bad type
    send_req(32'h0001_0001, 32'h0);
    cfg_read(A_STAT, ST_ERR, "R3 error on type");
    cfg_write(A_CTRL, ABORT);

    // R8 abort mid-exchange
    send_req(32'h0000_0001, 32'h0);
    cfg_write(A_RMBX, 32'h0);
    cfg_write(A_CTRL, ABORT);
    cfg_read(A_STAT, 32'h0, "R8 abort mid-exchange status");
    cfg_read(A_RMBX, 32'h0, "R8 abort mid-exchange data");

    // R8 GO and ABORT in one write
    cfg_write(A_WMBX, 32'h0000_0001);
    cfg_write(A_CTRL, GO | ABORT);
    cfg_read(A_STAT, 32'h0, "R8 abort beats GO");

    // R2 overflow: dword 0 must survive a dropped write
    cfg_write(A_CTRL, ABORT);
    cfg_write(A_WMBX, 32'h0000_0001);
    for (int i = 1; i < DEPTH; i++) cfg_write(A_WMBX, 32'h0);
    cfg_write(A_WMBX, 32'hFFFF_FFFF);
    cfg_write(A_CTRL, GO);
    cfg_read(A_STAT, ST_RDY, "R2 full buffer request accepted");
    cfg_read(A_RMBX, 32'h0000_0001, "R2 overflow write dropped");

    repeat (4) @(posedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R1: pending reads actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule